// File: doc/BRIEF.md
# CFI Query Response Formatter

This block forms the read word a parallel flash returns while it is in identifier mode or in the common flash interface query mode. A read request carries a bus byte offset, a read size and the mode. Configuration inputs give the bank width (the bus width of the whole flash array), the width at which each flash device is used, and the widest width that device supports. The block converts the bus offset into an index into the query table, fetches a table byte or an identifier, and copies that value across the bus word so that each device in the bank appears to answer at once.

The query table is a read-only array of 82 bytes (indices 0x00 to 0x51), fixed by a parameter at elaboration. The manufacturer and device identifiers are also parameters. Command decoding and the contents of the table are handled elsewhere. A legacy mode covers arrays where no device width is configured. In that mode the offset is scaled more simply and the value is returned without replication.

Top module: `qry_resp_fmt`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it rises, rd_valid is 0 and rd_data is 0. Asserting rst_n low clears both at once, with no clock edge needed.
- R2: A request accepted with rd_en=1 at a rising edge sets rd_valid=1 and updates rd_data at that edge. With rd_en=0 at an edge, rd_valid goes to 0 and rd_data holds its value.
- R3: Widths are given as log2 of their byte count (0=1, 1=2, 2=4 bytes). Outside legacy mode, the table index of a slice equals its byte offset shifted right by bank_lg2 + max_lg2 - dev_lg2.
- R4: A query index of 0x52 or above yields zero for that slice. Index 0x51 still returns the last table byte.
- R5: If the device width equals its maximum, a query places the table byte in the lowest byte of each device-width slice of the bank and zeroes the other bytes of that slice.
- R6: If dev_lg2 < max_lg2 and dev_lg2 = 0 (a wide part used at x8), every byte of the bank carries the table byte. Any other dev_lg2 < max_lg2, and any dev_lg2 > max_lg2, yields zero.
- R7: rd_ident=1 selects identifier mode. Index bits [7:0] equal to 0 select MAN_ID and equal to 1 select DEV_ID, and any other value (block-lock status offsets 2 and 3 included) yields zero. The identifier is cut to the device width, zero-extended if the device is wider, and copied into each device slice of the bank.
- R8: When the read size exceeds the bank width, slice k (k = 0, 1, ...) answers the byte offset rd_offset + k * bank bytes and sits at bits starting at k * bank * 8. Slices are formed while k * bank < read size.
- R9: With cfg_legacy=1, the index is rd_offset[7:0] shifted right by bank_lg2. A query returns the table byte, or zero at index 0x52 or above. An identifier read returns the 16-bit MAN_ID at index 0 and the 16-bit DEV_ID at index 1, otherwise zero. Nothing is replicated.
- R10: Bytes of rd_data at or above the read size (1 << rd_size_lg2 bytes) are zero.
- R11: bank_lg2, dev_lg2, max_lg2 and rd_size_lg2 never exceed 2 on an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request strobe |
| rd_ident | input | 1 | 1 = identifier mode, 0 = query mode |
| rd_offset | input | ADDR_W | Bus byte offset of the read |
| rd_size_lg2 | input | 2 | log2 of the read size in bytes |
| cfg_legacy | input | 1 | 1 = no device width configured (legacy scaling) |
| cfg_bank_lg2 | input | 2 | log2 of the bank width in bytes |
| cfg_dev_lg2 | input | 2 | log2 of the width each device is used at |
| cfg_max_lg2 | input | 2 | log2 of the widest width of the device |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Formatted read word |

## Verification
Query reads are run on x8, x16 and x32 banks built from parts used at full width. This shows whether the offset shift and the zero fill inside each device slice are correct. The same offsets are then read on wide parts used at x8 and on illegal width mixes, which separates byte repetition from zero fill and from the forced zero. Offsets just below and just above the table end, identifier offsets 0, 1, 2 and 0x100, reads wider than the bank, and legacy configurations each expose one scaling or packing path that the other patterns leave untouched.

// File: rtl/qrf_pkg.sv
package qrf_pkg;

  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = BUS_BYTES * 8;
  localparam int LG_W      = 2;

  typedef logic [LG_W-1:0] lg2_t;
  typedef logic [BUS_W-1:0] word_t;

  // Copy a per-device value into every device slice of the bank.
  function automatic word_t fill_bank(word_t per_dev, lg2_t dev_lg2, lg2_t bank_lg2);
    word_t r;
    int    src;
    r = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      src = j & ((1 << dev_lg2) - 1);
      if (j < (1 << bank_lg2)) r[j*8 +: 8] = per_dev[src*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/qrf_index.sv
module qrf_index
  import qrf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] off,
  input  logic              legacy,
  input  lg2_t              bank_lg2,
  input  lg2_t              dev_lg2,
  input  lg2_t              max_lg2,
  output logic [ADDR_W-1:0] idx,
  output logic              cfg_ok
);

  logic [2:0] shamt;

  always_comb begin
    cfg_ok = legacy || (dev_lg2 <= max_lg2);
    shamt  = '0;
    if (!legacy && cfg_ok)
      shamt = 3'(bank_lg2) + 3'(max_lg2) - 3'(dev_lg2);
    if (legacy)
      idx = {{(ADDR_W-8){1'b0}}, off[7:0]} >> bank_lg2;
    else
      idx = off >> shamt;
  end

endmodule

// File: rtl/qrf_slice.sv
module qrf_slice
  import qrf_pkg::*;
#(
  parameter int                     ADDR_W    = 16,
  parameter int                     TBL_DEPTH = 82,
  parameter logic [TBL_DEPTH*8-1:0] TBL_INIT  = '0,
  parameter logic [15:0]            MAN_ID    = 16'h0000,
  parameter logic [15:0]            DEV_ID    = 16'h0000
) (
  input  logic [ADDR_W-1:0] idx,
  input  logic              ident,
  input  logic              legacy,
  input  logic              cfg_ok,
  input  lg2_t              bank_lg2,
  input  lg2_t              dev_lg2,
  input  lg2_t              max_lg2,
  output word_t             val
);

  localparam int IDX_W = $clog2(TBL_DEPTH);

  logic [7:0]       rom [TBL_DEPTH];
  logic             in_range;
  logic [7:0]       tbyte;
  logic [15:0]      id_sel;
  logic [IDX_W-1:0] idx_s;

  for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_rom
    assign rom[i] = TBL_INIT[i*8 +: 8];
  end

  always_comb begin
    in_range = (idx < ADDR_W'(TBL_DEPTH));
    idx_s    = idx[IDX_W-1:0];
    tbyte    = in_range ? rom[idx_s] : 8'h00;
    if (legacy)
      id_sel = (idx == '0) ? MAN_ID : (idx == ADDR_W'(1)) ? DEV_ID : 16'h0000;
    else
      id_sel = (idx[7:0] == 8'd0) ? MAN_ID : (idx[7:0] == 8'd1) ? DEV_ID : 16'h0000;

    val = '0;
    if (legacy)
      val = ident ? word_t'(id_sel) : word_t'(tbyte);
    else if (!cfg_ok)
      val = '0;
    else if (ident)
      val = fill_bank(word_t'(id_sel), dev_lg2, bank_lg2);
    else if (dev_lg2 < max_lg2)
      val = (dev_lg2 == '0) ? fill_bank({BUS_BYTES{tbyte}}, '0, bank_lg2) : '0;
    else
      val = fill_bank(word_t'(tbyte), dev_lg2, bank_lg2);
  end

endmodule

// File: rtl/qry_resp_fmt.sv
module qry_resp_fmt
  import qrf_pkg::*;
#(
  parameter int                     ADDR_W    = 16,
  parameter int                     TBL_DEPTH = 82,
  parameter logic [TBL_DEPTH*8-1:0] TBL_INIT  = '0,
  parameter logic [15:0]            MAN_ID    = 16'h0089,
  parameter logic [15:0]            DEV_ID    = 16'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_ident,
  input  logic [ADDR_W-1:0] rd_offset,
  input  logic [1:0]        rd_size_lg2,
  input  logic              cfg_legacy,
  input  logic [1:0]        cfg_bank_lg2,
  input  logic [1:0]        cfg_dev_lg2,
  input  logic [1:0]        cfg_max_lg2,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);

  localparam int NSLICE = BUS_BYTES;

  logic [ADDR_W-1:0] s_off [NSLICE];
  logic [ADDR_W-1:0] s_idx [NSLICE];
  logic              s_ok  [NSLICE];
  word_t             s_val [NSLICE];

  word_t word;
  word_t size_mask;
  word_t data_d;
  logic  valid_d;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    assign s_off[k] = rd_offset + (ADDR_W'(k) << cfg_bank_lg2);

    qrf_index #(.ADDR_W(ADDR_W)) u_idx (
      .off      (s_off[k]),
      .legacy   (cfg_legacy),
      .bank_lg2 (cfg_bank_lg2),
      .dev_lg2  (cfg_dev_lg2),
      .max_lg2  (cfg_max_lg2),
      .idx      (s_idx[k]),
      .cfg_ok   (s_ok[k])
    );

    qrf_slice #(
      .ADDR_W    (ADDR_W),
      .TBL_DEPTH (TBL_DEPTH),
      .TBL_INIT  (TBL_INIT),
      .MAN_ID    (MAN_ID),
      .DEV_ID    (DEV_ID)
    ) u_fmt (
      .idx      (s_idx[k]),
      .ident    (rd_ident),
      .legacy   (cfg_legacy),
      .cfg_ok   (s_ok[k]),
      .bank_lg2 (cfg_bank_lg2),
      .dev_lg2  (cfg_dev_lg2),
      .max_lg2  (cfg_max_lg2),
      .val      (s_val[k])
    );
  end

  // Pack bank-width slices from the low end and trim to the read size.
  always_comb begin
    word = '0;
    if (cfg_legacy)
      word = s_val[0];
    else
      for (int k = 0; k < NSLICE; k++)
        if ((k << cfg_bank_lg2) < (1 << rd_size_lg2))
          word = word | (s_val[k] << ((k << cfg_bank_lg2) * 8));
    for (int j = 0; j < BUS_BYTES; j++)
      size_mask[j*8 +: 8] = (j < (1 << rd_size_lg2)) ? 8'hFF : 8'h00;
  end

  always_comb begin
    valid_d = rd_en;
    data_d  = rd_en ? (word & size_mask) : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_data  <= data_d;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data))); // R2
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cfg_bank_lg2 <= 2 && cfg_dev_lg2 <= 2 && cfg_max_lg2 <= 2 && rd_size_lg2 <= 2)); // R11
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_ident && !cfg_legacy && s_idx[0] >= ADDR_W'(TBL_DEPTH)) |-> (s_val[0] == '0)); // R4
  AST_BAD_MIX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !cfg_legacy && cfg_dev_lg2 > cfg_max_lg2) |-> (s_val[0] == '0)); // R6
  AST_X8_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_ident && !cfg_legacy && cfg_dev_lg2 == 2'd0 && cfg_max_lg2 != 2'd0 && cfg_bank_lg2 == 2'd2)
      |-> (s_val[0][7:0] == s_val[0][15:8] && s_val[0][15:8] == s_val[0][23:16]
           && s_val[0][23:16] == s_val[0][31:24])); // R6
  AST_NARROW_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size_lg2 == 2'd0) |=> (rd_data[31:8] == '0)); // R10

endmodule

// File: tb/tb_qry_resp_fmt.sv
`timescale 1ns/1ps
module tb_qry_resp_fmt;

  localparam int          ADDR_W = 16;
  localparam int          DEPTH  = 82;
  localparam logic [15:0] MAN    = 16'hA789;
  localparam logic [15:0] DEV    = 16'h3D1C;

  function automatic logic [7:0] tb_byte(int i);
    return 8'((i * 7 + 3) ^ 8'h5A);
  endfunction

  function automatic logic [DEPTH*8-1:0] make_tbl();
    logic [DEPTH*8-1:0] t;
    for (int i = 0; i < DEPTH; i++) t[i*8 +: 8] = tb_byte(i);
    return t;
  endfunction

  localparam logic [DEPTH*8-1:0] TBL = make_tbl();

  typedef struct packed {
    logic        ident;
    logic        legacy;
    logic [1:0]  bank;
    logic [1:0]  dev;
    logic [1:0]  mx;
    logic [1:0]  size;
    logic [15:0] off;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,2'd0,2'd0,2'd0,16'h0010,8'd5},  // R5 x8 bank
    '{1'b0,1'b0,2'd1,2'd1,2'd1,2'd1,16'h0020,8'd5},  // R5 x16 part at x16
    '{1'b0,1'b0,2'd2,2'd1,2'd1,2'd2,16'h0040,8'd5},  // R5 two x16 parts
    '{1'b0,1'b0,2'd2,2'd2,2'd2,2'd2,16'h0044,8'd3},  // R3 x32 part
    '{1'b0,1'b0,2'd1,2'd0,2'd1,2'd1,16'h0040,8'd6},  // R6 x16 part at x8
    '{1'b0,1'b0,2'd2,2'd0,2'd1,2'd2,16'h0080,8'd6},  // R6 four x16 at x8
    '{1'b0,1'b0,2'd2,2'd1,2'd2,2'd2,16'h0080,8'd6},  // R6 unsupported mix
    '{1'b0,1'b0,2'd1,2'd2,2'd1,2'd1,16'h0000,8'd6},  // R6 dev above max
    '{1'b0,1'b0,2'd0,2'd0,2'd0,2'd0,16'h0051,8'd4},  // R4 last entry
    '{1'b0,1'b0,2'd0,2'd0,2'd0,2'd0,16'h0052,8'd4},  // R4 first outside
    '{1'b0,1'b0,2'd1,2'd1,2'd1,2'd1,16'h00A4,8'd4},  // R4 scaled outside
    '{1'b0,1'b0,2'd0,2'd0,2'd0,2'd2,16'h0010,8'd8},  // R8 four slices
    '{1'b0,1'b0,2'd1,2'd1,2'd1,2'd2,16'h0020,8'd8},  // R8 two slices
    '{1'b0,1'b0,2'd0,2'd0,2'd0,2'd1,16'h0050,8'd8},  // R8 slices at end
    '{1'b0,1'b0,2'd0,2'd0,2'd0,2'd2,16'h0050,8'd4},  // R4 slices past end
    '{1'b0,1'b0,2'd2,2'd1,2'd1,2'd0,16'h0040,8'd10}, // R10 narrow read
    '{1'b1,1'b0,2'd1,2'd1,2'd1,2'd1,16'h0000,8'd7},  // R7 manufacturer
    '{1'b1,1'b0,2'd1,2'd1,2'd1,2'd1,16'h0002,8'd7},  // R7 device
    '{1'b1,1'b0,2'd1,2'd1,2'd1,2'd1,16'h0004,8'd7},  // R7 lock offset
    '{1'b1,1'b0,2'd2,2'd0,2'd0,2'd2,16'h0004,8'd7},  // R7 four x8 devices
    '{1'b1,1'b0,2'd1,2'd1,2'd1,2'd1,16'h0200,8'd7},  // R7 upper index bits
    '{1'b1,1'b0,2'd0,2'd0,2'd0,2'd1,16'h0000,8'd8},  // R8 ident pair
    '{1'b0,1'b1,2'd1,2'd0,2'd0,2'd1,16'h0024,8'd9},  // R9 legacy x16
    '{1'b0,1'b1,2'd2,2'd0,2'd0,2'd2,16'h0148,8'd9},  // R9 legacy wraps 256
    '{1'b1,1'b1,2'd1,2'd0,2'd0,2'd1,16'h0002,8'd9},  // R9 legacy device id
    '{1'b0,1'b1,2'd0,2'd0,2'd0,2'd0,16'h0060,8'd9},  // R9 legacy outside
    '{1'b1,1'b1,2'd2,2'd0,2'd0,2'd2,16'h0008,8'd9}   // R9 legacy lock offset
  };

  function automatic logic [31:0] model(vec_t v);
    int bb, db, mb, sb, ix, o, pos;
    logic [31:0] r, idv;
    logic [7:0]  e;
    bb = 1 << v.bank; db = 1 << v.dev; mb = 1 << v.mx; sb = 1 << v.size;
    r = '0;
    if (v.legacy) begin
      ix = int'(v.off[7:0]) / bb;
      if (v.ident) r = (ix == 0) ? 32'(MAN) : (ix == 1) ? 32'(DEV) : 32'h0;
      else         r = (ix < DEPTH) ? 32'(tb_byte(ix)) : 32'h0;
    end else begin
      for (int s = 0; s * bb < sb; s++) begin
        o = int'(v.off) + s * bb;
        for (int j = 0; j < bb; j++) begin
          e = 8'h00;
          if (db <= mb) begin
            ix = o / ((bb * mb) / db);
            if (v.ident) begin
              idv = ((ix % 256) == 0) ? 32'(MAN) : ((ix % 256) == 1) ? 32'(DEV) : 32'h0;
              e = idv[(j % db)*8 +: 8];
            end else if (ix < DEPTH) begin
              if (db < mb) e = (db == 1) ? tb_byte(ix) : 8'h00;
              else         e = ((j % db) == 0) ? tb_byte(ix) : 8'h00;
            end
          end
          pos = s * bb + j;
          if (pos < sb) r[pos*8 +: 8] = e;
        end
      end
    end
    for (int j = sb; j < 4; j++) r[j*8 +: 8] = 8'h00;
    return r;
  endfunction

  logic              clk, rst_n, rd_en, rd_ident, cfg_legacy, rd_valid;
  logic [ADDR_W-1:0] rd_offset;
  logic [1:0]        rd_size_lg2, cfg_bank_lg2, cfg_dev_lg2, cfg_max_lg2;
  logic [31:0]       rd_data;
  int                nchk, nfail;
  logic [31:0]       held;

  qry_resp_fmt #(
    .ADDR_W(ADDR_W), .TBL_DEPTH(DEPTH), .TBL_INIT(TBL), .MAN_ID(MAN), .DEV_ID(DEV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ident(rd_ident),
    .rd_offset(rd_offset), .rd_size_lg2(rd_size_lg2), .cfg_legacy(cfg_legacy),
    .cfg_bank_lg2(cfg_bank_lg2), .cfg_dev_lg2(cfg_dev_lg2), .cfg_max_lg2(cfg_max_lg2),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(bit ok, string req, logic [32:0] act, logic [32:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    logic [31:0] exp;
    exp = model(v);
    @(negedge clk);
    rd_en = 1'b1; rd_ident = v.ident; cfg_legacy = v.legacy; cfg_bank_lg2 = v.bank;
    cfg_dev_lg2 = v.dev; cfg_max_lg2 = v.mx; rd_size_lg2 = v.size; rd_offset = v.off;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b1 && rd_data === exp, $sformatf("R%0d", v.tag),
          {rd_valid, rd_data}, {1'b1, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0;
    rst_n = 1'b0; rd_en = 1'b0; rd_ident = 1'b0; cfg_legacy = 1'b0;
    cfg_bank_lg2 = 2'd0; cfg_dev_lg2 = 2'd0; cfg_max_lg2 = 2'd0;
    rd_size_lg2 = 2'd0; rd_offset = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    check(rd_valid === 1'b0 && rd_data === 32'h0, "R1", {rd_valid, rd_data}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === 32'h0, "R1", {rd_valid, rd_data}, 33'h0);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R2: idle cycles drop valid and hold data
    apply('{1'b0,1'b0,2'd2,2'd0,2'd1,2'd2,16'h0044,8'd2});
    held = rd_data;
    @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === held, "R2", {rd_valid, rd_data}, {1'b0, held});
    rd_offset = 16'h0013; rd_size_lg2 = 2'd1;
    @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === held, "R2", {rd_valid, rd_data}, {1'b0, held});

    // R1: asynchronous clear in the middle of operation
    apply('{1'b1,1'b0,2'd1,2'd1,2'd1,2'd1,16'h0000,8'd1});
    #1 rst_n = 1'b0;
    #1 check(rd_valid === 1'b0 && rd_data === 32'h0, "R1", {rd_valid, rd_data}, 33'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply('{1'b0,1'b0,2'd0,2'd0,2'd0,2'd0,16'h0011,8'd2}); // R2 after reset

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule